// File: doc/BRIEF.md
# Link Training and Test Pattern Source

This block sits in front of a 7:1 serializer. On every parallel clock it produces one 7-bit word for the clock lane and one 7-bit word for each of `LANES` data lanes, together with an output enable per lane. It has four modes: normal pass-through of user data, a built-in self test that sends a pseudo-random sequence, a deskew training sequence for the far-end receiver, and power-down, in which every lane output enable is deasserted.

The serializer takes a word on every clock, so the word interface is a plain registered stream with no valid/ready pair. User data is sampled on every edge and nothing can stall it, so there is no back-pressure. Mode control, the power-down input, the training start pulse and the training-done flag are plain level or pulse pins. Training runs for a lock interval (`LOCK_CYCLES`, set to the PLL lock time in clocks) plus a calibration window (`CAL_CYCLES`). When it ends, a level flag stays high until the next training start.

Top module: `link_pattern_src`

## Requirements
- R1: While `rst_n` is low, every lane word is zero, `lane_oe` is all zeros and `train_done` is low.
- R2: In normal mode (powered, not training, `prbs_en` low) the clock-lane word is 1111000 and data lane k outputs bits [7k+6:7k] of `data_in`, one cycle after they are sampled. `pat_sel` has no effect in this mode.
- R3: Modes take effect in this priority: power-down, then training, then self test, then normal. While powered, every bit of `lane_oe` is high one cycle later.
- R4: In self test with `pat_sel` low, every data lane carries the same word: the next 7 bits of a PRBS-15 sequence (x^15+x^14+1, new bit = s[14]^s[13], shifted in at bit 0, register seeded all-ones), with the first generated bit in word bit 6. The clock-lane word stays 1111000.
- R5: With `pat_sel` high, self test uses PRBS-23 (x^23+x^18+1, new bit = s[22]^s[17], seeded all-ones), with the same bit order and lane usage as R4.
- R6: In training with `dsk_opt` high, the clock-lane word is 1111000 (`ALT_WORDS`=0) or 1110000 (`ALT_WORDS`=1). All data lanes are all-ones on the first training cycle and then alternate between all-zeros and all-ones.
- R7: In training with `dsk_opt` low, the clock-lane word is 1111100 (`ALT_WORDS`=0) or 1100000 (`ALT_WORDS`=1). Every data lane carries 1111000 (`ALT_WORDS`=0) or 1110000 (`ALT_WORDS`=1) on every cycle.
- R8: A `train_start` pulse sampled while powered clears `train_done` and starts training for exactly `LOCK_CYCLES`+`CAL_CYCLES` output cycles. A pulse sampled during training restarts the full count. When training ends, `train_done` rises and stays high until the next accepted start.
- R9: While `pd_n` is low, `lane_oe` and all lane words are zero one cycle later, any training in progress is cancelled without setting `train_done`, and `train_start` is ignored.
- R10: Each entry into self test restarts the selected sequence from its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Power-down, active low |
| prbs_en | input | 1 | Self-test enable |
| pat_sel | input | 1 | Sequence select: 1 = PRBS-23, 0 = PRBS-15 |
| dsk_opt | input | 1 | Deskew option selecting the training word set |
| train_start | input | 1 | One-cycle pulse that starts training |
| data_in | input | LANES*7 | User words, lane k at bits [7k+6:7k] |
| clk_word | output | 7 | Clock-lane word to the serializer |
| data_word | output | LANES*7 | Data-lane words, lane k at bits [7k+6:7k] |
| lane_oe | output | LANES+1 | Output enables, bit 0 for the clock lane |
| train_done | output | 1 | Training complete, held until the next start |

## Verification
Every lane word and `lane_oe` follows the inputs sampled at the previous rising edge, so each result is due one edge after its stimulus. `train_done` rises on the edge that ends the last training output cycle, which is `LOCK_CYCLES`+`CAL_CYCLES` edges after the edge that sampled the start pulse. The driver applies inputs at the falling edge and pushes the outputs due after the next rising edge into a queue. The monitor pops one entry shortly after every rising edge, so each comparison lands on the exact cycle its result is due.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int WORD_W = 7;

  typedef enum logic [1:0] {MD_OFF, MD_TRAIN, MD_BIST, MD_NORM} mode_t;

  localparam logic [WORD_W-1:0] CLK_NORM = 7'b1111000;
  localparam logic [WORD_W-1:0] CLK_HI_A = 7'b1111000;
  localparam logic [WORD_W-1:0] CLK_HI_B = 7'b1110000;
  localparam logic [WORD_W-1:0] CLK_LO_A = 7'b1111100;
  localparam logic [WORD_W-1:0] CLK_LO_B = 7'b1100000;
  localparam logic [WORD_W-1:0] DAT_LO_A = 7'b1111000;
  localparam logic [WORD_W-1:0] DAT_LO_B = 7'b1110000;

  function automatic logic [WORD_W-1:0] pick(input bit alt,
                                              input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b);
    return alt ? b : a;
  endfunction
endpackage

// File: rtl/lps_prbs.sv
module lps_prbs #(
  parameter int LEN = 15,
  parameter int TAP = 14,
  parameter int W = 7,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] word
);
  logic [LEN-1:0] st, nxt;
  logic [W-1:0]   wd;

  always_comb begin
    logic fb;
    nxt = st;
    wd  = '0;
    for (int i = 0; i < W; i++) begin
      fb = nxt[LEN-1] ^ nxt[TAP-1];
      wd[W-1-i] = fb;
      nxt = {nxt[LEN-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= SEED;
    else if (run) st <= nxt;
    else          st <= SEED;
  end

  assign word = wd;

  assert_state_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  assert_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> st == SEED);
endmodule

// File: rtl/lps_train.sv
module lps_train #(
  parameter int LOCK_CYCLES = 2660000,
  parameter int CAL_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic start,
  output logic active,
  output logic phase,
  output logic done
);
  localparam int TRAIN_LEN = LOCK_CYCLES + CAL_CYCLES;
  localparam int CW = $clog2(TRAIN_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      phase  <= 1'b0;
    end else if (!pwr_ok) begin
      active <= 1'b0;
      cnt    <= '0;
      phase  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      done   <= 1'b0;
      phase  <= 1'b0;
    end else if (active) begin
      phase <= ~phase;
      if (cnt == CW'(TRAIN_LEN - 1)) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && done));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && pwr_ok)) |=> done);
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pwr_ok) |=> (active && !done));
  assert_pd_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !active);
endmodule

// File: rtl/link_pattern_src.sv
module link_pattern_src
  import lps_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LOCK_CYCLES = 2660000,
  parameter int CAL_CYCLES = 4096,
  parameter bit ALT_WORDS = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pd_n,
  input  logic                      prbs_en,
  input  logic                      pat_sel,
  input  logic                      dsk_opt,
  input  logic                      train_start,
  input  logic [LANES*WORD_W-1:0]   data_in,
  output logic [WORD_W-1:0]         clk_word,
  output logic [LANES*WORD_W-1:0]   data_word,
  output logic [LANES:0]            lane_oe,
  output logic                      train_done
);
  localparam logic [WORD_W-1:0] CLK_HI = pick(ALT_WORDS, CLK_HI_A, CLK_HI_B);
  localparam logic [WORD_W-1:0] CLK_LO = pick(ALT_WORDS, CLK_LO_A, CLK_LO_B);
  localparam logic [WORD_W-1:0] DAT_LO = pick(ALT_WORDS, DAT_LO_A, DAT_LO_B);

  mode_t mode;
  logic  tr_act, tr_phase, bist_run;
  logic [WORD_W-1:0] w15, w23, bist_w, train_w, clk_nxt;
  logic [LANES*WORD_W-1:0] data_nxt;

  lps_train #(.LOCK_CYCLES(LOCK_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_train (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pd_n), .start(train_start),
    .active(tr_act), .phase(tr_phase), .done(train_done));

  always_comb begin
    if (!pd_n)        mode = MD_OFF;
    else if (tr_act)  mode = MD_TRAIN;
    else if (prbs_en) mode = MD_BIST;
    else              mode = MD_NORM;
  end

  assign bist_run = (mode == MD_BIST);

  lps_prbs #(.LEN(15), .TAP(14), .W(WORD_W)) u_p15 (
    .clk(clk), .rst_n(rst_n), .run(bist_run), .word(w15));
  lps_prbs #(.LEN(23), .TAP(18), .W(WORD_W)) u_p23 (
    .clk(clk), .rst_n(rst_n), .run(bist_run), .word(w23));

  assign bist_w  = pat_sel ? w23 : w15;
  assign train_w = dsk_opt ? (tr_phase ? '0 : '1) : DAT_LO;

  always_comb begin
    unique case (mode)
      MD_OFF:   clk_nxt = '0;
      MD_TRAIN: clk_nxt = dsk_opt ? CLK_HI : CLK_LO;
      default:  clk_nxt = CLK_NORM;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (mode)
        MD_OFF:   data_nxt[l*WORD_W +: WORD_W] = '0;
        MD_TRAIN: data_nxt[l*WORD_W +: WORD_W] = train_w;
        MD_BIST:  data_nxt[l*WORD_W +: WORD_W] = bist_w;
        default:  data_nxt[l*WORD_W +: WORD_W] = data_in[l*WORD_W +: WORD_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_word  <= '0;
      data_word <= '0;
      lane_oe   <= '0;
    end else begin
      clk_word  <= clk_nxt;
      data_word <= data_nxt;
      lane_oe   <= {(LANES+1){pd_n}};
    end
  end

  assert_pd_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (lane_oe == '0 && clk_word == '0));
  assert_on_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pd_n |=> &lane_oe);
  assert_norm_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !tr_act && !prbs_en) |=> clk_word == CLK_NORM);
  assert_opt_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && tr_act && dsk_opt) |=> (data_word == '0 || &data_word));
  assert_opt_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && tr_act && !dsk_opt) |=> clk_word == CLK_LO);
endmodule

// File: tb/link_pattern_src_bench.sv
module link_pattern_src_bench;
  localparam int LANES = 8;
  localparam int W = 7;
  localparam int LOCK = 16;
  localparam int CAL = 4096;
  localparam int TLEN = LOCK + CAL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, prbs_en = 1'b0, pat_sel = 1'b0, dsk_opt = 1'b0, train_start = 1'b0;
  logic [LANES*W-1:0] data_in = '0;
  logic [W-1:0] clk_word;
  logic [LANES*W-1:0] data_word;
  logic [LANES:0] lane_oe;
  logic train_done;

  link_pattern_src #(.LANES(LANES), .LOCK_CYCLES(LOCK), .CAL_CYCLES(CAL),
                     .ALT_WORDS(1'b0)) u_link_pattern_src (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .prbs_en(prbs_en), .pat_sel(pat_sel),
    .dsk_opt(dsk_opt), .train_start(train_start), .data_in(data_in),
    .clk_word(clk_word), .data_word(data_word), .lane_oe(lane_oe),
    .train_done(train_done));

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0] cw;
    logic [LANES*W-1:0] dw;
    logic [LANES:0] oe;
    logic done;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  bit m_act = 0, m_phase = 0, m_done = 0;
  int m_cnt = 0;
  logic [22:0] m_s15 = 23'h7FFF, m_s23 = 23'h7FFFFF;

  task automatic gen(input int len, input int tap, inout logic [22:0] s,
                     output logic [W-1:0] wd);
    logic [22:0] mask;
    logic fb;
    mask = (23'h1 << len) - 1;
    for (int i = 0; i < W; i++) begin
      fb = s[len-1] ^ s[tap-1];
      wd[W-1-i] = fb;
      s = ((s << 1) | 23'(fb)) & mask;
    end
  endtask

  task automatic cyc(input bit pd, input bit pe, input bit ps, input bit opt,
                     input bit st, input logic [LANES*W-1:0] din, input string ovr);
    exp_t e;
    logic [W-1:0] w15, w23;
    logic [22:0] t15, t23;
    pd_n = pd; prbs_en = pe; pat_sel = ps; dsk_opt = opt; train_start = st; data_in = din;
    t15 = m_s15; t23 = m_s23;
    gen(15, 14, t15, w15);
    gen(23, 18, t23, w23);
    if (!pd) begin
      e.cw = '0; e.dw = '0; e.oe = '0; e.tag = "R9";
    end else if (m_act) begin
      e.oe = '1;
      if (opt) begin
        e.cw = 7'b1111000; e.dw = m_phase ? '0 : '1; e.tag = "R6";
      end else begin
        e.cw = 7'b1111100; e.dw = {LANES{7'b1111000}}; e.tag = "R7";
      end
    end else if (pe) begin
      e.oe = '1; e.cw = 7'b1111000; e.dw = {LANES{ps ? w23 : w15}};
      e.tag = ps ? "R5" : "R4";
    end else begin
      e.oe = '1; e.cw = 7'b1111000; e.dw = din; e.tag = "R2";
    end
    if (ovr != "") e.tag = ovr;
    // state update
    if (pd && !m_act && pe) begin m_s15 = t15; m_s23 = t23; end
    else begin m_s15 = 23'h7FFF; m_s23 = 23'h7FFFFF; end
    if (!pd) begin
      m_act = 0; m_cnt = 0; m_phase = 0;
    end else if (st) begin
      m_act = 1; m_cnt = 0; m_done = 0; m_phase = 0;
    end else if (m_act) begin
      m_phase = ~m_phase;
      if (m_cnt == TLEN - 1) begin m_act = 0; m_done = 1; end
      else m_cnt++;
    end
    e.done = m_done;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      n_chk++;
      if (clk_word !== e.cw || data_word !== e.dw || lane_oe !== e.oe) begin
        n_fail++;
        $display("FAIL %s: clk=%b data=%h oe=%b expected clk=%b data=%h oe=%b",
                 e.tag, clk_word, data_word, lane_oe, e.cw, e.dw, e.oe);
      end
      n_chk++;
      if (train_done !== e.done) begin
        n_fail++;
        $display("FAIL R8 (%s): train_done=%b expected %b", e.tag, train_done, e.done);
      end
    end
  end

  function automatic logic [LANES*W-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (clk_word !== '0 || data_word !== '0 || lane_oe !== '0 || train_done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: clk=%b data=%h oe=%b done=%b expected all zero",
               clk_word, data_word, lane_oe, train_done);
    end
    rst_n = 1'b1;
    // R2: normal pass-through, pat_sel toggled has no effect
    for (int i = 0; i < 8; i++) cyc(1, 0, i[0], 0, 0, rnd(), "R2");
    // R4: PRBS-15
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, 0, rnd(), "");
    cyc(1, 0, 0, 0, 0, rnd(), "");
    // R5: PRBS-23
    for (int i = 0; i < 40; i++) cyc(1, 1, 1, 0, 0, rnd(), "");
    cyc(1, 0, 1, 0, 0, rnd(), "");
    // R10: re-entry restarts from seed
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 0, 0, rnd(), "R10");
    cyc(1, 0, 0, 0, 0, rnd(), "");
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0, rnd(), "R10");
    // R3: training beats self test; R6 option high; R8 full length
    cyc(1, 1, 1, 1, 1, rnd(), "R3");
    for (int i = 0; i < TLEN + 4; i++) cyc(1, 1, 1, 1, 0, rnd(), "");
    cyc(1, 0, 0, 1, 0, rnd(), "R8");
    // R7 option low; R8 restart mid-training
    cyc(1, 0, 0, 0, 1, rnd(), "R8");
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0, 0, rnd(), "");
    cyc(1, 0, 0, 0, 1, rnd(), "R8");
    for (int i = 0; i < TLEN + 3; i++) cyc(1, 0, 0, 0, 0, rnd(), "");
    // R9: power-down cancels training, start ignored, outputs off
    cyc(1, 0, 0, 1, 1, rnd(), "");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 1, 0, rnd(), "");
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, i == 2, rnd(), "R9");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 1, 0, rnd(), "R9");
    // R3: power-down beats everything
    cyc(0, 1, 1, 1, 0, rnd(), "R3");
    cyc(1, 0, 0, 0, 0, rnd(), "R3");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule